// File: doc/BRIEF.md
# Floating-Point Exception Control Register

This block is the control and status register of a small processor's floating-point unit, together with the logic that turns arithmetic conditions into traps. After every arithmetic operation the datapath reports a five-bit condition vector: invalid, divide-by-zero, overflow, underflow or denormal, and inexact or rounded. The block compares that vector against the software-programmed enable field. It records at most one cause bit, picking the highest-priority condition that is enabled. It gathers the conditions that were reported while their enable was clear into sticky flags. In the same cycle it tells the datapath whether the result may be written back.

Compare operations also load a four-bit compare code. The block raises three kinds of trap request, each with a vector code, and holds each request until the interrupt logic acknowledges it. An FP instruction issued while the processor-status FPU-enable input is low gives the disabled-unit trap. An unimplemented FP instruction issued with the unit enabled gives the unimplemented trap. An operation that leaves a cause bit set gives the arithmetic trap.

Software reads the whole register at any time and writes it in one cycle. Bits with no function always read as zero, and so does the two-bit rounding-mode field, because round-to-nearest is the only mode.

Top module: `fpx_ctrl`

## Requirements
- R1: After reset the register reads 0x00000000, no trap is requested and the trap code is 0.
- R2: A software write stores only bits 21:18 (compare code), 14:10 (cause), 9:5 (enable) and 4:0 (flags), each group ordered V,Z,O,U,I from bit 4 to bit 0 of the group; bits 31:22 and 17:15 always read 0 (bits 17:16 are the rounding mode, fixed at round-to-nearest).
- R3: Every operation strobe replaces the whole cause field, so a strobe that reports no enabled condition leaves the cause field at 0 after the clock edge.
- R4: When several reported conditions are enabled, only the highest-priority one is recorded as a cause, in the order V (status bit 4), Z (bit 3), O (bit 2), U (bit 1), I (bit 0).
- R5: Each reported condition whose enable bit is clear sets its flag bit; operations never clear flags.
- R6: `wb_ok` is high in the cycle of an operation strobe only when no reported condition is enabled; it is low whenever the strobe is low.
- R7: A compare operation loads the compare code (bit 21 less, 20 greater, 19 equal, 18 unordered) from `cmp_res`. If it reports invalid, the code becomes unordered (0001) when invalid is disabled and 0000 when invalid is enabled. Non-compare operations leave the code unchanged.
- R8: An operation that records a cause bit requests a trap with code 0x1D0 from the next cycle.
- R9: An FP instruction issued while the unit is disabled (`fpu_en` low, or a build without an FPU) requests a trap with code 0x1C0 from the next cycle.
- R10: An unimplemented FP instruction issued with the unit enabled requests a trap with code 0x1C8; an implemented instruction requests none.
- R11: Trap requests stay pending until acknowledged. The presented one is the highest pending in the order disabled, unimplemented, arithmetic. An acknowledge clears only the presented request, and a new request of the same kind in the same cycle wins.
- R12: A software write in the same cycle as an operation strobe sets the register to the written value. The operation still drives `wb_ok` and its trap from the enables held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fpu_en | input | 1 | FPU-enable bit from processor status |
| issue_valid | input | 1 | An FP instruction is issued this cycle |
| issue_unimp | input | 1 | The issued FP instruction is unimplemented |
| op_start | input | 1 | An arithmetic operation reports its status this cycle |
| op_cmp | input | 1 | The reported operation is a compare |
| op_status | input | 5 | Reported conditions V,Z,O,U,I (bit 4 to bit 0) |
| cmp_res | input | 4 | Compare outcome L,G,E,U (bit 3 to bit 0) |
| wb_ok | output | 1 | The result of this operation may be written back |
| sw_we | input | 1 | Software write strobe |
| sw_wdata | input | 32 | Software write data |
| csr_rdata | output | 32 | Current register value |
| trap_req | output | 1 | A trap request is pending |
| trap_code | output | 12 | Vector code of the presented trap request |
| trap_ack | input | 1 | Acknowledge of the presented request |

## Verification
The bench builds the block with its defaults: a 32-bit register, 12-bit trap codes, the FPU present, and vectors 0x1C0, 0x1C8 and 0x1D0. This makes all three trap kinds reachable, with `fpu_en` choosing between the disabled and unimplemented paths, so the arbitration order can be tested with two or three requests pending at once. Since the register is exactly 32 bits wide, an all-ones write shows every dead bit reading back as zero. A random phase then strobes operations, compares, issues, writes and acknowledges together, which reaches the case of a write colliding with an operation and the case of an acknowledge colliding with a new request.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
   // number of exception conditions in each field
   localparam int NEXC      = 5;
   // bit index of each condition inside a five-bit group
   localparam int EXC_V     = 4;
   localparam int EXC_Z     = 3;
   localparam int EXC_O     = 2;
   localparam int EXC_U     = 1;
   localparam int EXC_I     = 0;
   // field placement in the register word
   localparam int FLAG_LSB  = 0;
   localparam int EN_LSB    = 5;
   localparam int CAUSE_LSB = 10;
   localparam int RM_LSB    = 16;
   localparam int RM_W      = 2;
   localparam int CC_LSB    = 18;
   localparam int CC_W      = 4;
   localparam int USED_W    = CC_LSB + CC_W;
   // compare code value for an unordered result
   localparam logic [CC_W-1:0] CC_UNORD = 4'b0001;
   // trap kinds, highest priority in the top bit
   localparam int TRAP_KINDS = 3;
   localparam int TK_OFF     = 2;
   localparam int TK_UNIMP   = 1;
   localparam int TK_ARITH   = 0;
endpackage

// File: rtl/fpx_prio.sv
module fpx_prio #(
   parameter int N = 5
) (
   input  logic [N-1:0] hit,
   output logic [N-1:0] pick
);
   // above[i] is set when any bit above position i is set
   logic [N-1:0] above;

   if (N < 1) begin : g_bad_n
      $error("fpx_prio: N must be at least 1");
   end

   for (genvar i = 0; i < N; i++) begin : g_bit
      if (i == N - 1) begin : g_top
         assign above[i] = 1'b0;
      end else begin : g_low
         assign above[i] = above[i+1] | hit[i+1];
      end
      assign pick[i] = hit[i] & ~above[i];
   end
endmodule

// File: rtl/fpx_csr.sv
module fpx_csr
   import fpx_pkg::*;
#(
   parameter int REG_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sw_we,
   input  logic [REG_W-1:0] sw_wdata,
   input  logic             op_start,
   input  logic             op_cmp,
   input  logic [CC_W-1:0]  cmp_res,
   input  logic [NEXC-1:0]  op_status,
   input  logic [NEXC-1:0]  cause_pick,
   output logic [REG_W-1:0] csr_q,
   output logic [NEXC-1:0]  enable_q
);
   localparam logic [REG_W-1:0] GRP_ONES = REG_W'((1 << NEXC) - 1);
   localparam logic [REG_W-1:0] CC_ONES  = REG_W'((1 << CC_W) - 1);
   localparam logic [REG_W-1:0] WR_MASK  = (CC_ONES << CC_LSB)
                                         | (GRP_ONES << CAUSE_LSB)
                                         | (GRP_ONES << EN_LSB)
                                         | (GRP_ONES << FLAG_LSB);

   if (REG_W < USED_W) begin : g_bad_width
      $error("fpx_csr: REG_W too small for the field layout");
   end

   logic [REG_W-1:0] reg_q, reg_d;
   logic [NEXC-1:0]  flag_q;
   logic [CC_W-1:0]  cc_next;

   assign enable_q = reg_q[EN_LSB +: NEXC];
   assign flag_q   = reg_q[FLAG_LSB +: NEXC];

   // compare code: invalid overrides the compare result
   always_comb begin
      if (op_status[EXC_V]) begin
         cc_next = enable_q[EXC_V] ? '0 : CC_UNORD;
      end else begin
         cc_next = cmp_res;
      end
   end

   always_comb begin
      reg_d = reg_q;
      if (sw_we) begin
         reg_d = sw_wdata & WR_MASK;
      end else if (op_start) begin
         reg_d[CAUSE_LSB +: NEXC] = cause_pick;
         reg_d[FLAG_LSB +: NEXC]  = flag_q | (op_status & ~enable_q);
         if (op_cmp) begin
            reg_d[CC_LSB +: CC_W] = cc_next;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reg_q <= '0;
      end else begin
         reg_q <= reg_d;
      end
   end

   assign csr_q = reg_q;
endmodule

// File: rtl/fpx_trap_arb.sv
module fpx_trap_arb
   import fpx_pkg::*;
#(
   parameter int                CODE_W    = 12,
   parameter logic [CODE_W-1:0] VEC_OFF   = 12'h1C0,
   parameter logic [CODE_W-1:0] VEC_UNIMP = 12'h1C8,
   parameter logic [CODE_W-1:0] VEC_ARITH = 12'h1D0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              set_off,
   input  logic              set_unimp,
   input  logic              set_arith,
   input  logic              ack,
   output logic              req,
   output logic [CODE_W-1:0] code
);
   logic [TRAP_KINDS-1:0] pend_q, pend_d, grant, clr, setv;

   assign setv[TK_OFF]   = set_off;
   assign setv[TK_UNIMP] = set_unimp;
   assign setv[TK_ARITH] = set_arith;

   fpx_prio #(.N(TRAP_KINDS)) u_grant (
      .hit  (pend_q),
      .pick (grant)
   );

   assign req    = |pend_q;
   assign clr    = ack ? grant : '0;
   assign pend_d = (pend_q & ~clr) | setv;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= '0;
      end else begin
         pend_q <= pend_d;
      end
   end

   assign code = ({CODE_W{grant[TK_OFF]}}   & VEC_OFF)
               | ({CODE_W{grant[TK_UNIMP]}} & VEC_UNIMP)
               | ({CODE_W{grant[TK_ARITH]}} & VEC_ARITH);
endmodule

// File: rtl/fpx_ctrl.sv
module fpx_ctrl
   import fpx_pkg::*;
#(
   parameter int                REG_W     = 32,
   parameter int                CODE_W    = 12,
   parameter bit                HAS_FPU   = 1'b1,
   parameter logic [CODE_W-1:0] VEC_OFF   = 12'h1C0,
   parameter logic [CODE_W-1:0] VEC_UNIMP = 12'h1C8,
   parameter logic [CODE_W-1:0] VEC_ARITH = 12'h1D0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fpu_en,
   input  logic              issue_valid,
   input  logic              issue_unimp,
   input  logic              op_start,
   input  logic              op_cmp,
   input  logic [NEXC-1:0]   op_status,
   input  logic [CC_W-1:0]   cmp_res,
   output logic              wb_ok,
   input  logic              sw_we,
   input  logic [REG_W-1:0]  sw_wdata,
   output logic [REG_W-1:0]  csr_rdata,
   output logic              trap_req,
   output logic [CODE_W-1:0] trap_code,
   input  logic              trap_ack
);
   if (CODE_W < 1) begin : g_bad_code
      $error("fpx_ctrl: CODE_W must be positive");
   end
   if (VEC_OFF == VEC_UNIMP || VEC_OFF == VEC_ARITH || VEC_UNIMP == VEC_ARITH) begin : g_bad_vec
      $error("fpx_ctrl: trap vectors must be distinct");
   end

   logic            unit_on;
   logic [NEXC-1:0] en_q, hit, pick;

   // variant: without an FPU every issued instruction takes the disabled trap
   if (HAS_FPU) begin : g_fpu
      assign unit_on = fpu_en;
   end else begin : g_nofpu
      assign unit_on = 1'b0;
   end

   assign hit = op_start ? (op_status & en_q) : '0;

   fpx_prio #(.N(NEXC)) u_cause (
      .hit  (hit),
      .pick (pick)
   );

   assign wb_ok = op_start & ~|hit;

   fpx_csr #(.REG_W(REG_W)) u_csr (
      .clk        (clk),
      .rst_n      (rst_n),
      .sw_we      (sw_we),
      .sw_wdata   (sw_wdata),
      .op_start   (op_start),
      .op_cmp     (op_cmp),
      .cmp_res    (cmp_res),
      .op_status  (op_status),
      .cause_pick (pick),
      .csr_q      (csr_rdata),
      .enable_q   (en_q)
   );

   fpx_trap_arb #(
      .CODE_W    (CODE_W),
      .VEC_OFF   (VEC_OFF),
      .VEC_UNIMP (VEC_UNIMP),
      .VEC_ARITH (VEC_ARITH)
   ) u_trap (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_off   (issue_valid & ~unit_on),
      .set_unimp (issue_valid & unit_on & issue_unimp),
      .set_arith (|pick),
      .ack       (trap_ack),
      .req       (trap_req),
      .code      (trap_code)
   );
endmodule

// File: rtl/fpx_ctrl_chk.sv
module fpx_ctrl_chk
   import fpx_pkg::*;
#(
   parameter int                REG_W     = 32,
   parameter int                CODE_W    = 12,
   parameter bit                HAS_FPU   = 1'b1,
   parameter logic [CODE_W-1:0] VEC_OFF   = 12'h1C0,
   parameter logic [CODE_W-1:0] VEC_UNIMP = 12'h1C8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              fpu_en,
   input logic              issue_valid,
   input logic              issue_unimp,
   input logic              op_start,
   input logic              sw_we,
   input logic              wb_ok,
   input logic [REG_W-1:0]  csr_rdata,
   input logic              trap_req,
   input logic [CODE_W-1:0] trap_code,
   input logic              trap_ack
);
   logic [NEXC-1:0] cause_f;
   assign cause_f = csr_rdata[CAUSE_LSB +: NEXC];

   // R2: rounding mode always reads as round-to-nearest
   assert_rm_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      csr_rdata[RM_LSB +: RM_W] == '0);

   // R4: an operation records at most one cause
   assert_one_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
      op_start && !sw_we |=> $onehot0(cause_f));

   // R3: a clean operation leaves no cause behind
   assert_clean_op_R3: assert property (@(posedge clk) disable iff (!rst_n)
      op_start && !sw_we && wb_ok |=> cause_f == '0);

   // R6: a blocked write-back always goes with a recorded cause
   assert_blocked_wb_R6: assert property (@(posedge clk) disable iff (!rst_n)
      op_start && !sw_we && !wb_ok |=> cause_f != '0);

   // R6: no write-back permission without an operation
   assert_wb_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !op_start |-> !wb_ok);

   // R9: an issue with the unit off presents the disabled vector next
   assert_off_trap_R9: assert property (@(posedge clk) disable iff (!rst_n)
      issue_valid && !fpu_en |=> trap_req && trap_code == VEC_OFF);

   // R10: unimplemented issue with the unit on raises a request
   assert_unimp_trap_R10: assert property (@(posedge clk) disable iff (!rst_n)
      issue_valid && issue_unimp && fpu_en && HAS_FPU |=> trap_req);

   // R11: a request is held until acknowledged
   assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      trap_req && !trap_ack |=> trap_req);

   // R11: a held request with no acknowledge keeps a vector of at least its priority
   assert_off_stays_R11: assert property (@(posedge clk) disable iff (!rst_n)
      trap_req && trap_code == VEC_OFF && !trap_ack |=> trap_code == VEC_OFF);

   // R11: with an unimplemented request presented and no acknowledge, it remains or is pre-empted only by the disabled one
   assert_unimp_stays_R11: assert property (@(posedge clk) disable iff (!rst_n)
      trap_req && trap_code == VEC_UNIMP && !trap_ack |=>
         (trap_code == VEC_UNIMP || trap_code == VEC_OFF));
endmodule

bind fpx_ctrl fpx_ctrl_chk #(
   .REG_W     (REG_W),
   .CODE_W    (CODE_W),
   .HAS_FPU   (HAS_FPU),
   .VEC_OFF   (VEC_OFF),
   .VEC_UNIMP (VEC_UNIMP)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .fpu_en      (fpu_en),
   .issue_valid (issue_valid),
   .issue_unimp (issue_unimp),
   .op_start    (op_start),
   .sw_we       (sw_we),
   .wb_ok       (wb_ok),
   .csr_rdata   (csr_rdata),
   .trap_req    (trap_req),
   .trap_code   (trap_code),
   .trap_ack    (trap_ack)
);

// File: tb/tb_fpx_ctrl.sv
module tb_fpx_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        fpu_en = 1'b1;
   logic        issue_valid = 1'b0;
   logic        issue_unimp = 1'b0;
   logic        op_start = 1'b0;
   logic        op_cmp = 1'b0;
   logic [4:0]  op_status = '0;
   logic [3:0]  cmp_res = '0;
   logic        wb_ok;
   logic        sw_we = 1'b0;
   logic [31:0] sw_wdata = '0;
   logic [31:0] csr_rdata;
   logic        trap_req;
   logic [11:0] trap_code;
   logic        trap_ack = 1'b0;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   fpx_ctrl dut (
      .clk(clk), .rst_n(rst_n), .fpu_en(fpu_en),
      .issue_valid(issue_valid), .issue_unimp(issue_unimp),
      .op_start(op_start), .op_cmp(op_cmp), .op_status(op_status),
      .cmp_res(cmp_res), .wb_ok(wb_ok), .sw_we(sw_we),
      .sw_wdata(sw_wdata), .csr_rdata(csr_rdata), .trap_req(trap_req),
      .trap_code(trap_code), .trap_ack(trap_ack)
   );

   // ---------------- reference model ----------------
   logic [3:0] m_cc;
   logic [4:0] m_cause, m_en, m_flag;
   logic       m_off, m_uni, m_ari;

   function automatic logic [4:0] highest(input logic [4:0] h);
      for (int i = 4; i >= 0; i--) begin
         if (h[i]) return 5'(1) << i;
      end
      return 5'd0;
   endfunction

   logic [4:0] m_sel;
   logic       a_off, a_uni, a_ari;
   assign m_sel = op_start ? highest(op_status & m_en) : 5'd0;
   assign a_off = trap_ack && m_off;
   assign a_uni = trap_ack && !m_off && m_uni;
   assign a_ari = trap_ack && !m_off && !m_uni && m_ari;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_cc <= '0; m_cause <= '0; m_en <= '0; m_flag <= '0;
         m_off <= 1'b0; m_uni <= 1'b0; m_ari <= 1'b0;
      end else begin
         if (sw_we) begin
            m_cc    <= sw_wdata[21:18];
            m_cause <= sw_wdata[14:10];
            m_en    <= sw_wdata[9:5];
            m_flag  <= sw_wdata[4:0];
         end else if (op_start) begin
            m_cause <= m_sel;
            m_flag  <= m_flag | (op_status & ~m_en);
            if (op_cmp) m_cc <= op_status[4] ? (m_en[4] ? 4'b0000 : 4'b0001) : cmp_res;
         end
         m_off <= (m_off && !a_off) || (issue_valid && !fpu_en);
         m_uni <= (m_uni && !a_uni) || (issue_valid && fpu_en && issue_unimp);
         m_ari <= (m_ari && !a_ari) || (m_sel != 5'd0);
      end
   end

   function automatic logic [31:0] exp_rd();
      return {10'b0, m_cc, 2'b00, 1'b0, m_cause, m_en, m_flag};
   endfunction

   function automatic logic [11:0] exp_code();
      if (m_off) return 12'h1C0;
      if (m_uni) return 12'h1C8;
      if (m_ari) return 12'h1D0;
      return 12'h000;
   endfunction

   // compare every output once per cycle, away from the clock edge
   task automatic step(input string tag);
      logic exp_wb;
      #1;
      exp_wb = op_start && ((op_status & m_en) == 5'd0);
      checks++;
      if (csr_rdata !== exp_rd()) begin
         errors++;
         $display("FAIL %s csr_rdata got %h exp %h", tag, csr_rdata, exp_rd());
      end
      checks++;
      if (trap_req !== (m_off | m_uni | m_ari)) begin
         errors++;
         $display("FAIL %s trap_req got %b exp %b", tag, trap_req, m_off | m_uni | m_ari);
      end
      checks++;
      if (trap_code !== exp_code()) begin
         errors++;
         $display("FAIL %s trap_code got %h exp %h", tag, trap_code, exp_code());
      end
      checks++;
      if (wb_ok !== exp_wb) begin
         errors++;
         $display("FAIL %s wb_ok got %b exp %b", tag, wb_ok, exp_wb);
      end
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic quiet();
      issue_valid = 1'b0; issue_unimp = 1'b0; op_start = 1'b0; op_cmp = 1'b0;
      op_status = '0; cmp_res = '0; sw_we = 1'b0; sw_wdata = '0; trap_ack = 1'b0;
   endtask

   task automatic do_write(input logic [31:0] d, input string tag);
      sw_we = 1'b1; sw_wdata = d; step(tag); quiet(); step(tag);
   endtask

   task automatic do_op(input logic [4:0] st, input logic cmp, input logic [3:0] cr, input string tag);
      op_start = 1'b1; op_status = st; op_cmp = cmp; cmp_res = cr; step(tag); quiet(); step(tag);
   endtask

   task automatic do_issue(input logic en, input logic un, input string tag);
      fpu_en = en; issue_valid = 1'b1; issue_unimp = un; step(tag); quiet(); fpu_en = 1'b1; step(tag);
   endtask

   task automatic drain(input string tag);
      for (int k = 0; k < 4; k++) begin
         trap_ack = 1'b1; step(tag);
      end
      quiet(); step(tag);
   endtask

   initial begin
      quiet();
      @(negedge clk);
      step("R1"); step("R1");
      rst_n = 1'b1;
      step("R1");

      do_write(32'hFFFF_FFFF, "R2");
      do_write(32'h0000_0000, "R2");
      do_write(32'h0000_03E0, "R2");          // all enables

      do_op(5'b10101, 1'b0, 4'h0, "R4");      // V,O,I -> V
      step("R8");
      drain("R11");
      do_op(5'b00111, 1'b0, 4'h0, "R4");      // O over U,I
      do_op(5'b00011, 1'b0, 4'h0, "R4");      // U over I
      do_op(5'b00001, 1'b0, 4'h0, "R4");
      do_op(5'b01000, 1'b0, 4'h0, "R4");
      do_op(5'b00000, 1'b0, 4'h0, "R3");
      drain("R8");

      do_write(32'h0000_0020, "R5");          // only inexact enabled
      do_op(5'b11110, 1'b0, 4'h0, "R5");
      do_op(5'b11111, 1'b0, 4'h0, "R6");
      do_op(5'b00000, 1'b0, 4'h0, "R6");
      drain("R6");

      do_write(32'h0000_0000, "R7");
      do_op(5'b00000, 1'b1, 4'b0100, "R7");
      do_op(5'b00001, 1'b0, 4'b1000, "R7");   // not a compare
      do_op(5'b10000, 1'b1, 4'b0010, "R7");   // invalid, disabled
      do_write(32'h0000_0200, "R7");
      do_op(5'b10000, 1'b1, 4'b0010, "R7");   // invalid, enabled
      drain("R7");

      do_issue(1'b0, 1'b0, "R9");
      drain("R9");
      do_issue(1'b1, 1'b1, "R10");
      drain("R10");
      do_issue(1'b1, 1'b0, "R10");

      // stacked requests
      do_write(32'h0000_03E0, "R11");
      fpu_en = 1'b0; issue_valid = 1'b1; op_start = 1'b1; op_status = 5'b00100;
      step("R11");
      quiet(); fpu_en = 1'b1; issue_valid = 1'b1; issue_unimp = 1'b1;
      step("R11");
      quiet();
      step("R11");
      trap_ack = 1'b1; step("R11");
      trap_ack = 1'b0; step("R11");
      trap_ack = 1'b1; step("R11");
      trap_ack = 1'b1; op_start = 1'b1; op_status = 5'b00010; step("R11");
      quiet(); step("R11");
      drain("R11");

      // write collides with an operation
      sw_we = 1'b1; sw_wdata = 32'h0028_0041; op_start = 1'b1; op_status = 5'b11111; op_cmp = 1'b1;
      step("R12");
      quiet(); step("R12");
      drain("R12");

      // mixed random traffic
      for (int n = 0; n < 3000; n++) begin
         logic [31:0] r;
         r = $urandom;
         fpu_en      = r[0] | r[1];
         issue_valid = (r[4:2] == 3'd0);
         issue_unimp = r[5];
         op_start    = r[6] & r[7];
         op_cmp      = r[8];
         op_status   = r[13:9] & {r[14], r[15], r[16], r[17], 1'b1};
         cmp_res     = 4'(1) << r[19:18];
         sw_we       = (r[22:20] == 3'd0);
         sw_wdata    = $urandom;
         trap_ack    = r[23] & r[24];
         step("R8");
      end
      quiet();
      drain("R8");

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL R1 watchdog: cycles got 100000 exp fewer");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule